// File: doc/BRIEF.md
# Framed serial pixel packet transmitter

This block turns a parallel pixel stream into a continuous run of fixed-length serial packets for an external differential line driver. Every packet carries one data byte and the two video timing flags, line-valid and frame-valid, between a start bit and a stop bit. Because the flags travel in every packet, a receiver can recover line and frame sync from any packet. Packets keep flowing during blanking, so the framing never breaks while the link is up.

A select input picks the byte source: the top eight bits of a 10-bit raw sample, or an already processed byte. A bypass mode instead carries the full 10-bit raw sample in two packets, eight bits and then two. The block also gives an output-enable for the pad. The pad is tri-stated during reset and while either standby input is high. After standby ends, sending always restarts on a packet boundary.

Top module: `pix_serializer`

## Requirements
- R1: A packet is 12 serial clocks long, one bit per clock, in this order: start bit (1), data bits 0 to 7, line-valid, frame-valid, stop bit (0). While the link is enabled, each packet is followed at once by the next.
- R2: `load_stb` is high in the one cycle whose inputs are sampled. The start bit of the packet built from them appears on `ser_out` in the next cycle. In normal mode a word is sampled once every 12 clocks.
- R3: In normal mode, with `src_sel`=0 the data byte is `raw_pix[9:2]`. With `src_sel`=1 it is `proc_byte`.
- R4: With `bypass_mode`=1 at sampling, the packet carries `raw_pix[9:2]`. The packet that follows carries `{6'b0, raw_pix[1:0]}` of the same sample, and no new word is sampled for it (`load_stb` stays low).
- R5: Both packets of a bypass pair carry the line-valid and frame-valid values that were sampled with the pixel.
- R6: When line-valid is sampled low, the packet is still sent with all eight data bits 0, and frame-valid is carried as sampled.
- R7: While `rst` is high, `ser_oe` and `load_stb` are low. Reset cancels any packet in flight and any pending bypass second half.
- R8: While `stby_hard` or `stby_soft` is high, `ser_oe` and `load_stb` are low in the same cycle. The packet in flight is dropped.
- R9: On the cycle either standby or reset ends, `load_stb` is high. The next bits are a complete packet from its start bit, and a bypass pair restarts at its first half.
- R10: `ser_out` is 0 whenever `ser_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_hard | input | 1 | Hard standby; disables the output |
| stby_soft | input | 1 | Soft standby; disables the output |
| bypass_mode | input | 1 | 1: 10-bit raw sample sent as 8 + 2 bit packet pair |
| src_sel | input | 1 | Normal-mode byte source: 0 raw, 1 processed |
| raw_pix | input | 10 | Raw sensor sample |
| proc_byte | input | 8 | Processed pixel byte |
| line_vld | input | 1 | Line-valid flag |
| frame_vld | input | 1 | Frame-valid flag |
| load_stb | output | 1 | High in the cycle the inputs are sampled |
| ser_out | output | 1 | Serial packet data |
| ser_oe | output | 1 | Pad output-enable (low = high impedance) |

## Verification
Packets are sent from raw and processed sources using bytes with uneven bit patterns. A swapped data bit or a reversed bit order therefore changes the serial stream, and a wrong source pick gives a wrong byte. A bypass pair is run while the inputs change before its second half. This separates a design that holds the low bits and the flags from one that samples again. A blanking packet with an all-ones input byte shows that the data is zeroed while frame-valid still passes. Standby and reset are applied in the middle of a packet and then released. These runs expose any partial packet, a stale bypass half, or a late tri-state.

// File: rtl/pix_serializer_pkg.sv
package pix_serializer_pkg;

    parameter int DATA_W  = 8;
    parameter int RAW_W   = 10;
    localparam int LOW_W   = RAW_W - DATA_W;
    localparam int PKT_LEN = DATA_W + 4;
    localparam int SLOT_W  = $clog2(PKT_LEN);

    localparam logic START_LVL = 1'b1;
    localparam logic STOP_LVL  = 1'b0;

    typedef struct packed {
        logic              fv;
        logic              lv;
        logic [DATA_W-1:0] data;
    } pkt_fields_t;

    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } pair_half_e;

    // Bit 0 leaves first: start, data LSB..MSB, lv, fv, stop.
    function automatic logic [PKT_LEN-1:0] frame_packet(input pkt_fields_t f);
        return {STOP_LVL, f.fv, f.lv, f.data, START_LVL};
    endfunction

    // Blanking packets carry zero data.
    function automatic logic [DATA_W-1:0] blank_gate(input logic lv,
                                                     input logic [DATA_W-1:0] d);
        return lv ? d : '0;
    endfunction

endpackage

// File: rtl/pkt_slot_timer.sv
module pkt_slot_timer
    import pix_serializer_pkg::*;
(
    input  logic              clk,
    input  logic              clear,
    output logic              boundary,
    output logic              active,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PKT_LEN - 1);

    assign boundary = !clear && (!active || slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (clear) begin
            active <= 1'b0;
            slot   <= '0;
        end else if (boundary) begin
            active <= 1'b1;
            slot   <= '0;
        end else if (active) begin
            slot   <= slot + 1'b1;
        end
    end
endmodule

// File: rtl/pkt_composer.sv
module pkt_composer
    import pix_serializer_pkg::*;
(
    input  logic               clk,
    input  logic               clear,
    input  logic               boundary,
    input  logic               bypass_mode,
    input  logic               src_sel,
    input  logic [RAW_W-1:0]   raw_pix,
    input  logic [DATA_W-1:0]  proc_byte,
    input  logic               line_vld,
    input  logic               frame_vld,
    output logic               load_stb,
    output logic [PKT_LEN-1:0] pkt_word
);
    pair_half_e       half_q;
    logic [LOW_W-1:0] low_q;
    logic             lv_q;
    logic             fv_q;
    pkt_fields_t      fields;
    logic [DATA_W-1:0] fresh_byte;

    assign load_stb = boundary && (half_q == HALF_FIRST);

    always_comb begin
        if (bypass_mode || !src_sel)
            fresh_byte = raw_pix[RAW_W-1 -: DATA_W];
        else
            fresh_byte = proc_byte;

        if (half_q == HALF_SECOND) begin
            fields.lv   = lv_q;
            fields.fv   = fv_q;
            fields.data = blank_gate(lv_q, {{(DATA_W-LOW_W){1'b0}}, low_q});
        end else begin
            fields.lv   = line_vld;
            fields.fv   = frame_vld;
            fields.data = blank_gate(line_vld, fresh_byte);
        end
    end

    assign pkt_word = frame_packet(fields);

    always_ff @(posedge clk) begin
        if (clear) begin
            half_q <= HALF_FIRST;
            low_q  <= '0;
            lv_q   <= 1'b0;
            fv_q   <= 1'b0;
        end else if (boundary) begin
            if (half_q == HALF_SECOND) begin
                half_q <= HALF_FIRST;
            end else if (bypass_mode) begin
                half_q <= HALF_SECOND;
                low_q  <= raw_pix[LOW_W-1:0];
                lv_q   <= line_vld;
                fv_q   <= frame_vld;
            end
        end
    end
endmodule

// File: rtl/pkt_shifter.sv
module pkt_shifter
    import pix_serializer_pkg::*;
(
    input  logic               clk,
    input  logic               clear,
    input  logic               load,
    input  logic [PKT_LEN-1:0] word,
    output logic               bit_out
);
    logic [PKT_LEN-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (clear)
            sh_q <= '0;
        else if (load)
            sh_q <= word;
        else
            sh_q <= {1'b0, sh_q[PKT_LEN-1:1]};
    end

    assign bit_out = sh_q[0];
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
    import pix_serializer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stby_hard,
    input  logic              stby_soft,
    input  logic              bypass_mode,
    input  logic              src_sel,
    input  logic [RAW_W-1:0]  raw_pix,
    input  logic [DATA_W-1:0] proc_byte,
    input  logic              line_vld,
    input  logic              frame_vld,
    output logic              load_stb,
    output logic              ser_out,
    output logic              ser_oe
);
    logic               clear;
    logic               boundary;
    logic               active;
    logic [SLOT_W-1:0]  slot;
    logic [PKT_LEN-1:0] pkt_word;
    logic               bit_out;

    assign clear = rst || stby_hard || stby_soft;

    pkt_slot_timer u_timer (
        .clk      (clk),
        .clear    (clear),
        .boundary (boundary),
        .active   (active),
        .slot     (slot)
    );

    pkt_composer u_composer (
        .clk         (clk),
        .clear       (clear),
        .boundary    (boundary),
        .bypass_mode (bypass_mode),
        .src_sel     (src_sel),
        .raw_pix     (raw_pix),
        .proc_byte   (proc_byte),
        .line_vld    (line_vld),
        .frame_vld   (frame_vld),
        .load_stb    (load_stb),
        .pkt_word    (pkt_word)
    );

    pkt_shifter u_shifter (
        .clk     (clk),
        .clear   (clear),
        .load    (boundary),
        .word    (pkt_word),
        .bit_out (bit_out)
    );

    assign ser_oe  = active && !clear;
    assign ser_out = ser_oe && bit_out;
endmodule

// File: rtl/pix_serializer_chk.sv
module pix_serializer_chk
    import pix_serializer_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic stby_hard,
    input logic stby_soft,
    input logic load_stb,
    input logic ser_out,
    input logic ser_oe
);
    logic [SLOT_W-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst || !ser_oe)
            bit_cnt <= '0;
        else if (bit_cnt == SLOT_W'(PKT_LEN - 1))
            bit_cnt <= '0;
        else
            bit_cnt <= bit_cnt + 1'b1;
    end

    always @(posedge clk) begin
        if (rst) begin
            assert_reset_quiet_R7: assert (!ser_oe && !load_stb)
                else $error("R7: output active during reset");
        end
    end

    assert_standby_off_R8: assert property (@(posedge clk) disable iff (rst)
        (stby_hard || stby_soft) |-> (!ser_oe && !load_stb));

    assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
        !ser_oe |-> !ser_out);

    assert_start_follows_R2: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> ((ser_oe && ser_out) || stby_hard || stby_soft || rst));

    assert_start_bit_R1: assert property (@(posedge clk) disable iff (rst)
        (ser_oe && bit_cnt == '0) |-> ser_out);

    assert_stop_bit_R1: assert property (@(posedge clk) disable iff (rst)
        (ser_oe && bit_cnt == SLOT_W'(PKT_LEN - 1)) |-> !ser_out);
endmodule

bind pix_serializer pix_serializer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .stby_hard (stby_hard),
    .stby_soft (stby_soft),
    .load_stb  (load_stb),
    .ser_out   (ser_out),
    .ser_oe    (ser_oe)
);

// File: tb/test_pix_serializer.sv
module test_pix_serializer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stby_hard = 1'b0;
    logic       stby_soft = 1'b0;
    logic       bypass_mode = 1'b0;
    logic       src_sel = 1'b0;
    logic [9:0] raw_pix = '0;
    logic [7:0] proc_byte = '0;
    logic       line_vld = 1'b0;
    logic       frame_vld = 1'b0;
    logic       load_stb;
    logic       ser_out;
    logic       ser_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_serializer i_pix_serializer (
        .clk(clk), .rst(rst), .stby_hard(stby_hard), .stby_soft(stby_soft),
        .bypass_mode(bypass_mode), .src_sel(src_sel), .raw_pix(raw_pix),
        .proc_byte(proc_byte), .line_vld(line_vld), .frame_vld(frame_vld),
        .load_stb(load_stb), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge on a packet boundary. Drives inputs, then
    // collects 12 bits and compares against the expected frame.
    task automatic run_pkt(input string req, input logic bp, input logic sel,
                           input logic [9:0] raw, input logic [7:0] prc,
                           input logic lv, input logic fv, input logic exp_load,
                           input logic [7:0] exp_data, input logic exp_lv,
                           input logic exp_fv);
        logic [11:0] got;
        logic [11:0] exp_word;
        logic [11:0] oe_bits;
        bypass_mode = bp; src_sel = sel; raw_pix = raw; proc_byte = prc;
        line_vld = lv; frame_vld = fv;
        #1;
        check("R2", "load_stb", {11'b0, load_stb}, {11'b0, exp_load});
        exp_word = {1'b0, exp_fv, exp_lv, exp_data, 1'b1};
        @(posedge clk);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            got[i] = ser_out;
            oe_bits[i] = ser_oe;
        end
        check("R1", "oe over packet", oe_bits, 12'hFFF);
        check(req, "packet bits", got, exp_word);
    endtask

    // Sends part of a packet, then cancels it with reset or a standby.
    // kind: 0 reset, 1 soft standby, 2 hard standby.
    task automatic abort_mid(input int kind, input string req);
        bypass_mode = 1'b1; src_sel = 1'b0; raw_pix = 10'h3FF;
        line_vld = 1'b1; frame_vld = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 5; i++) @(negedge clk);
        if (kind == 0) rst = 1'b1;
        else if (kind == 1) stby_soft = 1'b1;
        else stby_hard = 1'b1;
        #1;
        check(req, "oe off at once", {11'b0, ser_oe}, 12'h0);
        check(req, "load_stb off", {11'b0, load_stb}, 12'h0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(req, "oe held off", {11'b0, ser_oe}, 12'h0);
            check("R10", "out low while off", {11'b0, ser_out}, 12'h0);
        end
        rst = 1'b0; stby_soft = 1'b0; stby_hard = 1'b0;
    endtask

    task automatic test_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R7", "oe in reset", {11'b0, ser_oe}, 12'h0);
        check("R7", "load_stb in reset", {11'b0, load_stb}, 12'h0);
        check("R10", "out in reset", {11'b0, ser_out}, 12'h0);
        rst = 1'b0;
    endtask

    task automatic test_normal;
        run_pkt("R3", 1'b0, 1'b0, 10'h2CE, 8'h11, 1'b1, 1'b1, 1'b1, 8'hB3, 1'b1, 1'b1);
        run_pkt("R3", 1'b0, 1'b1, 10'h155, 8'h5A, 1'b1, 1'b0, 1'b1, 8'h5A, 1'b1, 1'b0);
        run_pkt("R1", 1'b0, 1'b1, 10'h000, 8'h81, 1'b1, 1'b1, 1'b1, 8'h81, 1'b1, 1'b1);
    endtask

    task automatic test_blanking;
        run_pkt("R6", 1'b0, 1'b1, 10'h3FF, 8'hFF, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
        run_pkt("R6", 1'b0, 1'b0, 10'h3FF, 8'hFF, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic test_bypass;
        run_pkt("R4", 1'b1, 1'b1, 10'h2CE, 8'h77, 1'b1, 1'b1, 1'b1, 8'hB3, 1'b1, 1'b1);
        // Inputs change before the second half; it must use the held sample (R5).
        run_pkt("R5", 1'b1, 1'b1, 10'h001, 8'h77, 1'b0, 1'b0, 1'b0, 8'h02, 1'b1, 1'b1);
        run_pkt("R4", 1'b1, 1'b0, 10'h1A5, 8'h00, 1'b1, 1'b0, 1'b1, 8'h69, 1'b1, 1'b0);
        run_pkt("R5", 1'b1, 1'b0, 10'h3FE, 8'h00, 1'b1, 1'b1, 1'b0, 8'h01, 1'b1, 1'b0);
    endtask

    task automatic test_standby;
        abort_mid(1, "R8");
        run_pkt("R9", 1'b1, 1'b0, 10'h155, 8'h00, 1'b1, 1'b1, 1'b1, 8'h55, 1'b1, 1'b1);
        run_pkt("R4", 1'b1, 1'b0, 10'h000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 1'b1, 1'b1);
        abort_mid(2, "R8");
        run_pkt("R9", 1'b0, 1'b1, 10'h000, 8'hC6, 1'b1, 1'b0, 1'b1, 8'hC6, 1'b1, 1'b0);
    endtask

    task automatic test_mid_reset;
        abort_mid(0, "R7");
        run_pkt("R9", 1'b0, 1'b0, 10'h0F0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_normal();
        test_blanking();
        test_bypass();
        test_standby();
        test_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule